// File: doc/BRIEF.md
# Master-to-Frame Clock Ratio Monitor

This block measures how many master-clock cycles fit into one period of an audio frame clock. It sorts that count into one of three legal oversampling ratios (256, 384 or 512) or rejects it. The frame clock is asynchronous to the block, so it passes through a synchronizer first. Everything else runs on the master clock.

Downstream logic uses three outputs. A qualified-ratio flag gates the audio path. A ratio code selects the serial format. A divide value sets how many master cycles make up one internal bit-clock period: 32 bit clocks per frame at 256 and 512, and 48 per frame at 384.

A single-cycle fault strobe marks every moment the clock relationship stops being usable. That covers an illegal count, a switch between two legal ratios, a badly skewed frame-clock duty cycle, a saturated period count, and a frame clock that has stopped.

Top module: `clk_ratio_monitor`

## Requirements
- R1: While reset is asserted and right after it, `ratio_ok_o` is 0, `ratio_code_o` is 0, `bclk_div_o` is 0 and `fault_o` is 0.
- R2: A period is the number of master cycles between two consecutive synchronized rising frame-clock edges. The first rising edge after reset, or after a timeout, only starts a measurement. `ratio_ok_o` rises only after two consecutive measured periods fall in the same legal class.
- R3: A measured period P is in class 256, 384 or 512 when it lies within plus or minus TOL (default 1) of that value. The `ratio_code_o` encoding is 1 for 256, 2 for 384 and 3 for 512.
- R4: While qualified, `bclk_div_o` is 8 for code 1, 8 for code 2 and 16 for code 3. Whenever `ratio_ok_o` is 0, both `ratio_code_o` and `bclk_div_o` read 0.
- R5: A period outside every legal class clears `ratio_ok_o` on the first such frame.
- R6: A legal period whose class differs from the qualified class clears `ratio_ok_o`. The new ratio is qualified again only after two consecutive frames agree on it.
- R7: `fault_o` pulses for exactly one cycle each time `ratio_ok_o` falls, and never otherwise. Further bad frames while unqualified raise no fault.
- R8: If no frame-clock edge of either polarity reaches the synchronized domain for TIMEOUT (default 1024) master cycles, `ratio_ok_o` clears and the next rising edge only restarts measurement.
- R9: The period counter saturates at CNT_MAX (default 1023) instead of wrapping, and a saturated period is illegal.
- R10: With the duty-cycle check enabled (default), a frame whose high time H and period P give |2H - P| > 2*TOL is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_clk_i | input | 1 | Frame (sample-rate) clock, asynchronous |
| ratio_ok_o | output | 1 | Ratio qualified |
| ratio_code_o | output | 2 | 0 none, 1 = 256, 2 = 384, 3 = 512 |
| bclk_div_o | output | 5 | Master cycles per internal bit clock, 0 when unqualified |
| fault_o | output | 1 | One-cycle strobe when the qualification is lost |

## Verification
A corrupted class register or stale previous-class memory shows up as a wrong code or divide value, or as a missing or spurious fault. The defect becomes visible at the first rising frame edge after the bad state appears, which is at most one frame period plus the synchronizer and measurement pipeline.

A broken timeout or saturation counter shows differently. The qualified flag stays high while the frame clock is stopped, or an over-long period is accepted. Each of these is visible within about TIMEOUT cycles of the stimulus. Checks at frame boundaries and mid-stall expose all of these through the output ports alone.

// File: rtl/crm_pkg.sv
package crm_pkg;

   typedef enum logic [1:0] {
      RC_NONE = 2'd0,
      RC_256  = 2'd1,
      RC_384  = 2'd2,
      RC_512  = 2'd3
   } ratio_e;

   localparam int unsigned BASE_256 = 256;
   localparam int unsigned BASE_384 = 384;
   localparam int unsigned BASE_512 = 512;
   localparam int unsigned DIV_W    = 5;

   function automatic logic [DIV_W-1:0] div_of(input ratio_e rc);
      case (rc)
         RC_256:  div_of = 5'd8;
         RC_384:  div_of = 5'd8;
         RC_512:  div_of = 5'd16;
         default: div_of = 5'd0;
      endcase
   endfunction

endpackage

// File: rtl/crm_sync.sv
module crm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/crm_period_meter.sv
module crm_period_meter #(
   parameter int unsigned CNT_MAX = 1023,
   parameter int unsigned TIMEOUT = 1024,
   localparam int unsigned CNT_W  = $clog2(CNT_MAX + 1),
   localparam int unsigned TMO_W  = $clog2(TIMEOUT + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             lvl_i,
   output logic             meas_stb_o,
   output logic [CNT_W-1:0] period_o,
   output logic [CNT_W-1:0] high_len_o,
   output logic             tmo_stb_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);
   localparam logic [TMO_W-1:0] TMO_TOP = TMO_W'(TIMEOUT);
   localparam logic [TMO_W-1:0] TMO_HIT = TMO_W'(TIMEOUT - 1);

   logic             lvl_q, armed_q;
   logic [CNT_W-1:0] cnt_q, hlen_q;
   logic [TMO_W-1:0] idle_q;
   logic             rise, fall, tmo_now;

   assign rise    = lvl_i & ~lvl_q;
   assign fall    = ~lvl_i & lvl_q;
   assign tmo_now = (idle_q == TMO_HIT) & ~rise & ~fall;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lvl_q      <= 1'b0;
         armed_q    <= 1'b0;
         cnt_q      <= '0;
         hlen_q     <= '0;
         idle_q     <= '0;
         meas_stb_o <= 1'b0;
         period_o   <= '0;
         high_len_o <= '0;
         tmo_stb_o  <= 1'b0;
      end else begin
         lvl_q      <= lvl_i;
         meas_stb_o <= rise & armed_q;
         tmo_stb_o  <= tmo_now;
         if (rise) begin
            period_o   <= cnt_q;
            high_len_o <= hlen_q;
            cnt_q      <= CNT_W'(1);
         end else if (cnt_q != CNT_TOP) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
         if (fall) hlen_q <= cnt_q;
         if (rise | fall)            idle_q <= '0;
         else if (idle_q != TMO_TOP) idle_q <= idle_q + TMO_W'(1);
         if (tmo_now)   armed_q <= 1'b0;
         else if (rise) armed_q <= 1'b1;
      end
   end

   assert_cnt_saturates_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CNT_TOP && !rise) |=> (cnt_q == CNT_TOP));

   assert_timeout_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmo_stb_o |=> !tmo_stb_o);
endmodule

// File: rtl/crm_classify.sv
module crm_classify
   import crm_pkg::*;
#(
   parameter int unsigned CNT_MAX    = 1023,
   parameter int unsigned TOL        = 1,
   parameter bit          DUTY_CHECK = 1'b1,
   localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1)
) (
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] high_len_i,
   output ratio_e           cls_o
);
   logic duty_ok, sat, near256, near384, near512;
   int   p, h2;

   assign p  = int'(period_i);
   assign h2 = 2 * int'(high_len_i);

   function automatic logic near(input int val, input int unsigned base);
      near = (val + int'(TOL) >= int'(base)) && (val <= int'(base) + int'(TOL));
   endfunction

   generate
      if (DUTY_CHECK) begin : g_duty
         assign duty_ok = (h2 + 2 * int'(TOL) >= p) && (h2 <= p + 2 * int'(TOL));
      end else begin : g_noduty
         assign duty_ok = 1'b1;
      end
   endgenerate

   assign sat     = (p == int'(CNT_MAX));
   assign near256 = near(p, BASE_256);
   assign near384 = near(p, BASE_384);
   assign near512 = near(p, BASE_512);

   always_comb begin
      cls_o = RC_NONE;
      if (!sat && duty_ok) begin
         if (near256)      cls_o = RC_256;
         else if (near384) cls_o = RC_384;
         else if (near512) cls_o = RC_512;
      end
   end

   always_comb begin
      assert_sat_illegal_R9: assert (!(sat && cls_o != RC_NONE));
   end
endmodule

// File: rtl/crm_qualifier.sv
module crm_qualifier
   import crm_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             meas_stb_i,
   input  ratio_e           cls_i,
   input  logic             tmo_stb_i,
   output logic             ok_o,
   output ratio_e           code_o,
   output logic [DIV_W-1:0] div_o,
   output logic             fault_o
);
   ratio_e prev_q, code_q;
   logic   ok_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q  <= RC_NONE;
         code_q  <= RC_NONE;
         ok_q    <= 1'b0;
         fault_o <= 1'b0;
      end else begin
         fault_o <= 1'b0;
         if (tmo_stb_i) begin
            fault_o <= ok_q;
            ok_q    <= 1'b0;
            code_q  <= RC_NONE;
            prev_q  <= RC_NONE;
         end else if (meas_stb_i) begin
            prev_q <= cls_i;
            if (ok_q) begin
               if (cls_i != code_q) begin
                  ok_q    <= 1'b0;
                  code_q  <= RC_NONE;
                  fault_o <= 1'b1;
               end
            end else if (cls_i != RC_NONE && cls_i == prev_q) begin
               ok_q   <= 1'b1;
               code_q <= cls_i;
            end
         end
      end
   end

   assign ok_o   = ok_q;
   assign code_o = code_q;
   assign div_o  = div_of(code_q);

   assert_fault_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |=> !fault_o);
   assert_fault_on_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> (!ok_q && $past(ok_q)));
   assert_lock_needs_meas_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ok_q) |-> $past(meas_stb_i));
   assert_code_when_ok_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ok_q |-> (code_q != RC_NONE && div_o != '0));
   assert_tmo_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmo_stb_i |=> !ok_q);
endmodule

// File: rtl/clk_ratio_monitor.sv
module clk_ratio_monitor
   import crm_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_MAX     = 1023,
   parameter int unsigned TIMEOUT     = 1024,
   parameter int unsigned TOL         = 1,
   parameter bit          DUTY_CHECK  = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       frame_clk_i,
   output logic       ratio_ok_o,
   output logic [1:0] ratio_code_o,
   output logic [4:0] bclk_div_o,
   output logic       fault_o
);
   localparam int unsigned CNT_W = $clog2(CNT_MAX + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_MAX <= BASE_512 + TOL) begin : g_bad_cnt
         $error("CNT_MAX must exceed the largest legal period");
      end
      if (TIMEOUT <= BASE_512 / 2 + TOL) begin : g_bad_tmo
         $error("TIMEOUT must exceed the longest legal half period");
      end
      if (TOL >= 64) begin : g_bad_tol
         $error("TOL would merge ratio classes");
      end
   endgenerate

   logic             lvl, meas_stb, tmo_stb;
   logic [CNT_W-1:0] period, high_len;
   ratio_e           cls, code;

   crm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(frame_clk_i), .q_o(lvl));

   crm_period_meter #(.CNT_MAX(CNT_MAX), .TIMEOUT(TIMEOUT)) u_meter (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl),
      .meas_stb_o(meas_stb), .period_o(period), .high_len_o(high_len),
      .tmo_stb_o(tmo_stb));

   crm_classify #(.CNT_MAX(CNT_MAX), .TOL(TOL), .DUTY_CHECK(DUTY_CHECK)) u_cls (
      .period_i(period), .high_len_i(high_len), .cls_o(cls));

   crm_qualifier u_qual (
      .clk_i(clk_i), .rst_ni(rst_ni), .meas_stb_i(meas_stb), .cls_i(cls),
      .tmo_stb_i(tmo_stb), .ok_o(ratio_ok_o), .code_o(code),
      .div_o(bclk_div_o), .fault_o(fault_o));

   assign ratio_code_o = code;

   assert_idle_outputs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ratio_ok_o |-> (ratio_code_o == 2'd0 && bclk_div_o == 5'd0));
endmodule

// File: tb/tb_clk_ratio_monitor.sv
module tb_clk_ratio_monitor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fr = 1'b0;
   logic       ok;
   logic [1:0] code;
   logic [4:0] div;
   logic       fault;
   int         n_chk = 0, n_bad = 0, n_fault = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   clk_ratio_monitor dut (
      .clk_i(clk), .rst_ni(rst_n), .frame_clk_i(fr),
      .ratio_ok_o(ok), .ratio_code_o(code), .bclk_div_o(div), .fault_o(fault));

   always @(posedge clk) if (rst_n && fault) n_fault++;

   function automatic int code_of(input int ratio);
      case (ratio)
         256: return 1;
         384: return 2;
         512: return 3;
         default: return 0;
      endcase
   endfunction

   function automatic int div_for(input int c);
      case (c)
         1: return 8;
         2: return 8;
         3: return 16;
         default: return 0;
      endcase
   endfunction

   task automatic check(input bit cond, input string tag, input int act, input int exp);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_state(input string tag, input int ev, input int ec);
      check(ok == ev[0], {tag, " ok"}, int'(ok), ev);
      check(int'(code) == ec, {tag, " code"}, int'(code), ec);
      check(int'(div) == div_for(ec), {tag, " div"}, int'(div), div_for(ec));
   endtask

   task automatic frame(input int p, input int h);
      fr = 1'b1;
      repeat (h) @(negedge clk);
      fr = 1'b0;
      repeat (p - h) @(negedge clk);
   endtask

   task automatic frames(input int n, input int p);
      for (int i = 0; i < n; i++) frame(p, p / 2);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int f0, prev_c;
      void'($urandom(32'd20240611));
      repeat (10) @(negedge clk);
      chk_state("R1 in reset", 0, 0);
      check(fault == 1'b0, "R1 fault", int'(fault), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_state("R1 after reset", 0, 0);

      // R2: two frames give only one measurement
      frames(2, 256);
      chk_state("R2 not yet", 0, 0);
      frames(2, 256);
      chk_state("R2 lock 256", 1, 1);
      check(n_fault == 0, "R7 no fault at lock", n_fault, 0);

      // R3/R6: jittered 512 replaces 256
      f0 = n_fault;
      frame(511, 255); frame(513, 256); frame(512, 256);
      chk_state("R3 R6 lock 512 with jitter", 1, 3);
      check(n_fault == f0 + 1, "R6 fault on ratio change", n_fault - f0, 1);

      // R5: illegal ratio
      f0 = n_fault;
      frames(3, 300);
      chk_state("R5 illegal 300", 0, 0);
      check(n_fault == f0 + 1, "R7 fault on drop", n_fault - f0, 1);
      frames(3, 300);
      check(n_fault == f0 + 1, "R7 no fault while unqualified", n_fault - f0, 1);

      frames(4, 384);
      chk_state("R6 relock 384", 1, 2);

      // R5 out of tolerance, R3 edges of tolerance
      f0 = n_fault;
      frame(386, 193); frame(384, 192);
      chk_state("R5 386 rejected", 0, 0);
      check(n_fault == f0 + 1, "R5 fault", n_fault - f0, 1);
      frame(383, 191); frame(385, 192);
      chk_state("R3 383/385 accepted", 1, 2);

      // R10 duty
      f0 = n_fault;
      frame(256, 100); frame(256, 100); frame(256, 100);
      chk_state("R10 skewed duty", 0, 0);
      check(n_fault == f0 + 1, "R10 fault", n_fault - f0, 1);
      frame(256, 127); frame(256, 129); frame(256, 128);
      chk_state("R10 duty at limit", 1, 1);

      // R8 timeout
      f0 = n_fault;
      repeat (700) @(negedge clk);
      check(ok == 1'b1, "R8 still ok before timeout", int'(ok), 1);
      repeat (400) @(negedge clk);
      chk_state("R8 timeout", 0, 0);
      check(n_fault == f0 + 1, "R8 fault", n_fault - f0, 1);
      frames(2, 256);
      chk_state("R2 restart after timeout", 0, 0);
      frames(2, 256);
      chk_state("R2 relock after timeout", 1, 1);

      // R9 saturation
      f0 = n_fault;
      frames(3, 1408);
      chk_state("R9 saturated period", 0, 0);
      check(n_fault == f0 + 1, "R9 fault", n_fault - f0, 1);

      // random legal ratios with jitter
      prev_c = 0;
      for (int it = 0; it < 10; it++) begin
         int r, c;
         case ($urandom_range(0, 2))
            0: r = 256;
            1: r = 384;
            default: r = 512;
         endcase
         c  = code_of(r);
         f0 = n_fault;
         for (int k = 0; k < 4; k++) begin
            int p;
            p = r + $urandom_range(0, 2) - 1;
            frame(p, p / 2);
         end
         chk_state("R3 R4 random", 1, c);
         check(n_fault - f0 == ((prev_c != 0 && prev_c != c) ? 1 : 0),
               "R6 random fault count", n_fault - f0,
               (prev_c != 0 && prev_c != c) ? 1 : 0);
         prev_c = c;
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule